// File: doc/BRIEF.md
# Nibble-Mode Serial Access Sequencer

This block sits between a memory core that is four bits wide inside and a pin interface that carries one data bit each way. Accesses are framed by an active-low row strobe and an active-low column strobe. Both are sampled on the clock, and the address pins are shared between the row and the column. On the first column strobe of a row cycle, the block reads one four-bit word from the core. Each later column strobe then steps a circulating one-hot selector to the next bit of that word. The selector therefore produces a burst of single-bit transfers, and they are much faster than the first access because none of them touches the core.

The two low address bits latched with the first column address choose the starting bit. The selector then turns through the four lanes and wraps back to the start. The same selector serves reads and writes. A write strobe merges its data bit into the selected lane of the held word. When the row strobe rises, a row cycle that saw any write puts the merged word back into the core.

Top module: `nibble_seq`

## Requirements
- R1: On a sampled row strobe fall, the row address is latched from `addr`. On the first sampled column strobe fall in that row cycle, the column address is latched. `core_addr` carries the row in its upper bits and the column without its two low bits in its lower bits.
- R2: `core_rd` is high for exactly one cycle: the cycle after the clock edge that sampled the first column fall. `core_rdata` is captured at the end of that cycle, with bit i being lane i.
- R3: The first bit is valid (`dout_en` high) from two clock edges after the edge that sampled the first column fall. `dout` carries lane `col[1:0]`.
- R4: Each later sampled column fall moves the selected lane to (lane+1) mod 4, and the new bit is valid right after that same edge. After four bits, the selection is back at the starting lane.
- R5: `dout_en` is low when the column strobe was sampled high at the last edge, when no word is held, and during a write strobe.
- R6: A column fall sampled with `we_n` low stores `din` into the selected lane. On the first fall, this write overrides only that lane of the fetched word. Later reads in the same row cycle return the merged bits.
- R7: When the row strobe is sampled high after a row cycle with at least one write, `core_we` is high for one cycle on the following cycle. During it, `core_wdata` holds the merged word at the same `core_addr`. A row cycle with no write produces no `core_we`.
- R8: A row strobe rise ends the sequence, and the next row fall starts afresh. Column strobes while the row strobe is high cause no core read and leave `dout_en` low. A row strobe that rises during the fetch cycle still lets a pending first write be stored back.
- R9: After reset, `dout_en`, `core_rd` and `core_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled at column falls |
| addr | input | ADDR_W | Shared row/column address |
| din | input | 1 | Serial write data |
| dout | output | 1 | Serial read data |
| dout_en | output | 1 | High when `dout` is driven and valid |
| core_addr | output | 2*ADDR_W-2 | Core word address |
| core_rd | output | 1 | Core read request |
| core_rdata | input | LANES | Core read word, captured at the end of the `core_rd` cycle |
| core_we | output | 1 | Core write-back strobe |
| core_wdata | output | LANES | Core write-back word |

## Verification
The first serial bit appears two edges after the edge that samples the first column fall. `core_rd` is due one edge after that sampling edge. Every later bit, and every change of `dout_en` caused by the column strobe, is due one edge after its sampling edge. The write-back pulse is due one edge after the edge that samples the row strobe high. The bench holds a behavioural model that steps on the same edges as the design. It drives inputs and compares outputs on the falling clock edge, so each result is checked in the cycle it is due. Directed checks also pin the first-access latency, the absence of any effect from strobes outside a row cycle, and the core word left after a write-back.

// File: rtl/nibble_seq_pkg.sv
package nibble_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ROW,
        PH_FETCH,
        PH_NIB,
        PH_WB
    } phase_t;

    typedef struct packed {
        phase_t phase;
        logic   cas_q;
        logic   ras_q;
        logic   dirty;
        logic   pend_wr;
        logic   pend_din;
        logic   wr_strobe;
    } ctl_t;

endpackage

// File: rtl/nibble_ring.sv
module nibble_ring #(
    parameter int LANES = 4,
    parameter int IDX_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] start,
    input  logic             advance,
    output logic [LANES-1:0] sel_nxt,
    output logic [LANES-1:0] sel
);

    logic [LANES-1:0] sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (load) begin
            sel_d = LANES'(1) << start;
        end else if (advance) begin
            sel_d = {sel_q[LANES-2:0], sel_q[LANES-1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= LANES'(1);
        else        sel_q <= sel_d;
    end

    assign sel_nxt = sel_d;
    assign sel     = sel_q;

    // R3: loading selects exactly the addressed starting lane
    assert_ring_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sel_q == (LANES'(1) << $past(start)));

    // R4: a step keeps one lane selected and moves it
    assert_ring_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> ($countones(sel_q) == 1 && sel_q != $past(sel_q)));

endmodule

// File: rtl/nibble_lanes.sv
module nibble_lanes #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LANES-1:0] load_data,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_sel,
    input  logic             wr_bit,
    input  logic [LANES-1:0] rd_sel,
    output logic [LANES-1:0] lanes,
    output logic             rd_bit
);

    logic [LANES-1:0] lanes_d, lanes_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            lanes_d[i] = lanes_q[i];
            if (wr_en && wr_sel[i]) lanes_d[i] = wr_bit;
            else if (load)          lanes_d[i] = load_data[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lanes_q <= '0;
        else        lanes_q <= lanes_d;
    end

    assign lanes  = lanes_q;
    assign rd_bit = |(lanes_q & rd_sel);

    // R6: the written lane holds the written bit on the next cycle
    assert_lane_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lanes_q & $past(wr_sel)) == ($past(wr_bit) ? $past(wr_sel) : '0));

endmodule

// File: rtl/nibble_seq.sv
module nibble_seq
    import nibble_seq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    localparam int IDX_W   = $clog2(LANES),
    localparam int CORE_AW = 2 * ADDR_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               din,
    output logic               dout,
    output logic               dout_en,
    output logic [CORE_AW-1:0] core_addr,
    output logic               core_rd,
    input  logic [LANES-1:0]   core_rdata,
    output logic               core_we,
    output logic [LANES-1:0]   core_wdata
);

    ctl_t              c_d, c_q;
    logic [ADDR_W-1:0] row_d, row_q, col_d, col_q;
    logic              ring_load, ring_adv;
    logic              buf_load, buf_wr, wr_bit;
    logic              cas_fall, ras_fall;
    logic [LANES-1:0]  sel_nxt, sel;

    assign cas_fall = c_q.cas_q & ~cas_n;
    assign ras_fall = c_q.ras_q & ~ras_n;

    always_comb begin
        c_d       = c_q;
        row_d     = row_q;
        col_d     = col_q;
        ring_load = 1'b0;
        ring_adv  = 1'b0;
        buf_load  = 1'b0;
        buf_wr    = 1'b0;
        wr_bit    = din;
        c_d.cas_q = cas_n;
        c_d.ras_q = ras_n;
        unique case (c_q.phase)
            PH_IDLE: begin
                if (ras_fall) begin
                    row_d      = addr;
                    c_d.dirty  = 1'b0;
                    c_d.phase  = PH_ROW;
                end
            end
            PH_ROW: begin
                if (ras_n) begin
                    c_d.phase = PH_IDLE;
                end else if (cas_fall) begin
                    col_d         = addr;
                    ring_load     = 1'b1;
                    c_d.pend_wr   = ~we_n;
                    c_d.pend_din  = din;
                    c_d.wr_strobe = ~we_n;
                    c_d.phase     = PH_FETCH;
                end
            end
            PH_FETCH: begin
                buf_load  = 1'b1;
                buf_wr    = c_q.pend_wr;
                wr_bit    = c_q.pend_din;
                c_d.dirty = c_q.pend_wr;
                if (ras_n) c_d.phase = c_q.pend_wr ? PH_WB : PH_IDLE;
                else       c_d.phase = PH_NIB;
            end
            PH_NIB: begin
                if (ras_n) begin
                    c_d.phase = c_q.dirty ? PH_WB : PH_IDLE;
                end else if (cas_fall) begin
                    ring_adv      = 1'b1;
                    c_d.wr_strobe = ~we_n;
                    if (!we_n) begin
                        buf_wr    = 1'b1;
                        c_d.dirty = 1'b1;
                    end
                end
            end
            PH_WB: begin
                c_d.phase = PH_IDLE;
            end
            default: c_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q   <= '{phase: PH_IDLE, cas_q: 1'b1, ras_q: 1'b1, dirty: 1'b0,
                       pend_wr: 1'b0, pend_din: 1'b0, wr_strobe: 1'b0};
            row_q <= '0;
            col_q <= '0;
        end else begin
            c_q   <= c_d;
            row_q <= row_d;
            col_q <= col_d;
        end
    end

    nibble_ring #(.LANES(LANES), .IDX_W(IDX_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ring_load),
        .start   (addr[IDX_W-1:0]),
        .advance (ring_adv),
        .sel_nxt (sel_nxt),
        .sel     (sel)
    );

    nibble_lanes #(.LANES(LANES)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (buf_load),
        .load_data (core_rdata),
        .wr_en     (buf_wr),
        .wr_sel    (sel_nxt),
        .wr_bit    (wr_bit),
        .rd_sel    (sel),
        .lanes     (core_wdata),
        .rd_bit    (dout)
    );

    assign core_addr = {row_q, col_q[ADDR_W-1:IDX_W]};
    assign core_rd   = (c_q.phase == PH_FETCH);
    assign core_we   = (c_q.phase == PH_WB);
    assign dout_en   = (c_q.phase == PH_NIB) & ~c_q.cas_q & ~c_q.wr_strobe;

    // R2: a core read follows an edge that saw both strobes low
    assert_rd_after_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_rd |-> ($past(!cas_n) && $past(!ras_n)));

    // R2: the core read lasts one cycle
    assert_rd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_rd |=> !core_rd);

    // R5: valid data only while the column strobe was sampled low
    assert_dout_needs_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!cas_n));

    // R7: write-back only after the row strobe was sampled high
    assert_wb_after_ras_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |-> $past(ras_n));

    // R7: write-back is a single pulse and never overlaps a read
    assert_wb_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |=> (!core_we && !core_rd));

endmodule

// File: tb/nibble_seq_bench.sv
module nibble_seq_bench;

    localparam int ADDR_W  = 8;
    localparam int LANES   = 4;
    localparam int CORE_AW = 2 * ADDR_W - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic               dout, dout_en, core_rd, core_we;
    logic [CORE_AW-1:0] core_addr;
    logic [LANES-1:0]   core_rdata = '0;
    logic [LANES-1:0]   core_wdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nibble_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_nibble_seq (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .core_addr(core_addr), .core_rd(core_rd), .core_rdata(core_rdata),
        .core_we(core_we), .core_wdata(core_wdata)
    );

    // core storage: untouched words follow a fixed pattern
    int mem [int];
    function automatic int core_word(int a);
        if (mem.exists(a)) return mem[a];
        return (a * 5 + 9) & 15;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int              m_ph;
    int              m_lane;
    bit              m_casp, m_rasp, m_dirty, m_pw, m_pd, m_wrs;
    bit [3:0]        m_buf;
    bit [ADDR_W-1:0] m_row, m_col;

    always @(posedge clk) begin
        bit fc, fr;
        if (!rst_n) begin
            m_ph = 0; m_casp = 1; m_rasp = 1; m_wrs = 0; m_dirty = 0;
        end else begin
            fc = m_casp && !cas_n;
            fr = m_rasp && !ras_n;
            case (m_ph)
                0: if (fr) begin m_row = addr; m_dirty = 0; m_ph = 1; end
                1: if (ras_n) m_ph = 0;
                   else if (fc) begin
                       m_col = addr; m_lane = int'(addr) % 4;
                       m_pw = !we_n; m_pd = din; m_wrs = !we_n; m_ph = 2;
                   end
                2: begin
                       m_buf = core_rdata;
                       if (m_pw) begin m_buf[m_lane] = m_pd; m_dirty = 1; end
                       m_ph = ras_n ? (m_pw ? 4 : 0) : 3;
                   end
                3: if (ras_n) m_ph = m_dirty ? 4 : 0;
                   else if (fc) begin
                       m_lane = (m_lane + 1) % 4;
                       m_wrs = !we_n;
                       if (!we_n) begin m_buf[m_lane] = din; m_dirty = 1; end
                   end
                default: m_ph = 0;
            endcase
            m_casp = cas_n;
            m_rasp = ras_n;
        end
    end

    // compare on every falling edge, then service the core
    always @(negedge clk) begin
        bit e_en;
        bit [CORE_AW-1:0] e_addr;
        if (rst_n) begin
            e_en   = (m_ph == 3) && !m_casp && !m_wrs;
            e_addr = {m_row, m_col[ADDR_W-1:2]};
            chk(dout_en == e_en, "R5 dout_en", int'(dout_en), int'(e_en));
            if (e_en) chk(dout == m_buf[m_lane], "R4 dout", int'(dout), int'(m_buf[m_lane]));
            chk(core_rd == (m_ph == 2), "R2 core_rd", int'(core_rd), int'(m_ph == 2));
            chk(core_we == (m_ph == 4), "R7 core_we", int'(core_we), int'(m_ph == 4));
            if (m_ph == 4) chk(core_wdata == m_buf, "R6 core_wdata", int'(core_wdata), int'(m_buf));
            if (m_ph == 2 || m_ph == 4)
                chk(core_addr == e_addr, "R1 core_addr", int'(core_addr), int'(e_addr));
        end
        if (core_we) mem[int'(core_addr)] = int'(core_wdata);
        core_rdata = LANES'(core_word(int'(core_addr)));
    end

    task automatic ras_down(input logic [ADDR_W-1:0] r);
        ras_n = 0; addr = r;
        repeat (2) @(negedge clk);
    endtask

    task automatic ras_up(input int n);
        ras_n = 1; cas_n = 1; we_n = 1;
        repeat (n) @(negedge clk);
    endtask

    task automatic cas_pulse(input logic [ADDR_W-1:0] c, input bit wr, input bit d,
                             input int lo, input int hi);
        cas_n = 0; addr = c; we_n = !wr; din = d;
        repeat (lo) @(negedge clk);
        cas_n = 1; we_n = 1;
        repeat (hi) @(negedge clk);
    endtask

    initial begin
        int wb_a, base;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(dout_en == 0, "R9 dout_en", int'(dout_en), 0);
        chk(core_rd == 0, "R9 core_rd", int'(core_rd), 0);
        chk(core_we == 0, "R9 core_we", int'(core_we), 0);
        rst_n = 1;
        @(negedge clk);

        // R3: first-access latency, start lane 0, then six more bits with wrap (R4)
        ras_down(8'h35);
        cas_n = 0; addr = 8'h40;
        @(negedge clk);
        chk(dout_en == 0, "R3 one edge after first fall", int'(dout_en), 0);
        @(negedge clk);
        chk(dout_en == 1, "R3 two edges after first fall", int'(dout_en), 1);
        chk(dout == core_word({8'h35, 6'h10}) % 2, "R3 first bit lane 0", int'(dout),
            core_word({8'h35, 6'h10}) % 2);
        cas_n = 1; @(negedge clk);
        for (int i = 0; i < 6; i++) cas_pulse(8'h00, 0, 0, 1, 1);
        ras_up(2);

        // read starting at lane 2, slower strobes
        ras_down(8'hA7);
        cas_pulse(8'h9E, 0, 0, 3, 2);
        for (int i = 0; i < 4; i++) cas_pulse(8'h00, 0, 0, 3, 2);
        ras_up(2);

        // R6 / R7: write burst starting at lane 3, mixed reads and writes
        wb_a = {8'h35, 6'h10};
        base = core_word(wb_a);
        ras_down(8'h35);
        cas_pulse(8'h43, 1, 1, 2, 1);
        cas_pulse(8'h00, 0, 0, 1, 1);
        cas_pulse(8'h00, 1, 0, 1, 1);
        cas_pulse(8'h00, 0, 0, 1, 1);
        cas_pulse(8'h00, 0, 0, 1, 1);
        ras_up(3);
        chk(core_word(wb_a) == ((base & 4'b0101) | 4'b1000), "R7 stored word",
            core_word(wb_a), (base & 4'b0101) | 4'b1000);

        // R8: fresh row cycle reads back the merged word from lane 1
        ras_down(8'h35);
        cas_pulse(8'h41, 0, 0, 2, 1);
        for (int i = 0; i < 4; i++) cas_pulse(8'h00, 0, 0, 1, 1);
        ras_up(2);

        // R8: column strobes with the row strobe high do nothing
        for (int i = 0; i < 3; i++) begin
            cas_n = 0; addr = 8'h12;
            @(negedge clk);
            chk(core_rd == 0, "R8 no read without row", int'(core_rd), 0);
            @(negedge clk);
            chk(dout_en == 0, "R8 no data without row", int'(dout_en), 0);
            cas_n = 1; @(negedge clk);
        end

        // R8: row strobe rises during the fetch with a pending write
        ras_down(8'h5C);
        cas_n = 0; addr = 8'h22; we_n = 0; din = 0;
        @(negedge clk);
        ras_n = 1;
        @(negedge clk);
        cas_n = 1; we_n = 1;
        repeat (3) @(negedge clk);
        chk(core_word({8'h5C, 6'h08}) % 8 / 4 == 0, "R8 early-close write",
            core_word({8'h5C, 6'h08}) % 8 / 4, 0);

        // row cycle with no column strobe, then a plain read
        ras_down(8'h01);
        ras_up(2);
        ras_down(8'hFF);
        cas_pulse(8'hFF, 0, 0, 2, 1);
        for (int i = 0; i < 4; i++) cas_pulse(8'h00, 0, 0, 2, 1);
        ras_up(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule